// File: doc/BRIEF.md
# Power-Enable Request Controller

This block decides when a rail-sequencing engine should begin or end its power-up sequence. It watches a power-enable pin, a shutdown input, an undervoltage-lockout flag and two software command strobes (on and off), and it combines them under a set of static configuration fields into one registered power-request level. A one-cycle start pulse marks each rise of that level and a one-cycle stop pulse marks each fall.

The pin passes through a synchronizer and a tick-based filter. A 1 ms tick input from outside sets the filter time. Configuration then selects one of three start sources: automatic, software only, or the pin. In pin mode the filtered pin can act as a level, as a rising-edge trigger, or as a push-button, where each qualified press toggles the request. A software off command and the shutdown input override everything else. The undervoltage flag gates the output without losing the stored request.

Top module: `pwr_req_ctrl`

## Requirements
- R1: After reset, `pwr_req`, `seq_start` and `seq_stop` are all low.
- R2: `dbnc_sel` picks the filter length: 0 = no filter (the synchronized pin is taken directly), 1 = 25 ticks, 2 = 50 ticks, 3 = 100 ticks. A pin change is accepted only on the tick that completes that many ticks during which the synchronized pin has differed from the accepted value.
- R3: If the pin returns to the accepted value before the count completes, the count restarts from zero and the request does not change.
- R4: With `src_sel` = 2 (pin) and `pin_mode` = 0 (level; code 3 acts the same), an accepted rise sets the request and an accepted fall clears it.
- R5: With `src_sel` = 2 and `pin_mode` = 1 (edge), an accepted rise sets the request and an accepted fall leaves it unchanged.
- R6: With `src_sel` = 2 and `pin_mode` = 2 (push-button), each accepted high-to-low transition toggles the request. Accepted rises have no effect.
- R7: With `src_sel` = 0 (automatic), the request is set once, on the first tick after reset on which `uvlo` and `shdn` are both low. It is not set again until the next reset.
- R8: A `sw_on` strobe sets the request in every source mode. With `src_sel` = 1 (software), pin activity has no effect.
- R9: A `sw_off` strobe clears the request whatever the pin state, and it wins over `sw_on` and pin events in the same cycle. A pin that stays high afterwards does not restore the request.
- R10: While `shdn` is high, `pwr_req` is low, the stored request is cleared, and `sw_on` is ignored. The request stays off after `shdn` falls.
- R11: While `uvlo` is high, `pwr_req` is low. The stored request is kept, and `pwr_req` returns when `uvlo` clears.
- R12: `pwr_req` is registered and updates on the clock edge after its cause. `seq_start` is high for exactly the first cycle of each high period of `pwr_req`, and `seq_stop` is high for exactly the first low cycle after a high period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_ms | input | 1 | One-cycle pulse every millisecond |
| pen_pin | input | 1 | Raw power-enable pin, asynchronous |
| shdn | input | 1 | Shutdown, high forces everything off |
| uvlo | input | 1 | High while the internal supply is below threshold |
| sw_on | input | 1 | Software power-on strobe |
| sw_off | input | 1 | Software power-off strobe |
| src_sel | input | 2 | Start source: 0 auto, 1 software, 2 pin |
| pin_mode | input | 2 | Pin mode: 0 level, 1 edge, 2 push-button |
| dbnc_sel | input | 2 | Filter length select (see R2) |
| pwr_req | output | 1 | Registered power-request level |
| seq_start | output | 1 | One-cycle pulse on each rise of `pwr_req` |
| seq_stop | output | 1 | One-cycle pulse on each fall of `pwr_req` |

## Verification
The filter is tested by holding the pin for one tick less than the selected length, which must give no change, and then for exactly the full length, at the 25- and 100-tick settings and with the filter off. Interrupted holds whose total exceeds the limit are also used, to separate a count that restarts from one that only accumulates. The same pin sequences are applied in level, edge and push-button modes, so each mode's response to a rise and to a fall is told apart. Software strobes, shutdown and lockout are then mixed in, including `sw_on` and `sw_off` in the same cycle and a pin held high after a software off, to pin down priority.

// File: rtl/pwr_req_pkg.sv
// Shared encodings for the power-request controller.
// Assumes configuration fields are static while a decision is in flight.
package pwr_req_pkg;
    typedef enum logic [1:0] {
        SRC_AUTO = 2'd0,
        SRC_SOFT = 2'd1,
        SRC_PIN  = 2'd2,
        SRC_RSVD = 2'd3
    } src_e;

    typedef enum logic [1:0] {
        PM_LEVEL  = 2'd0,
        PM_EDGE   = 2'd1,
        PM_BUTTON = 2'd2,
        PM_LEVEL2 = 2'd3
    } pin_mode_e;
endpackage

// File: rtl/pen_sync.sv
// Multi-flop synchronizer for the asynchronous enable pin.
// Assumes STAGES >= 2; output is low during reset.
module pen_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic d_out
);
    logic [STAGES-1:0] chain;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            // shift the pin one flop further along the chain
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= 1'b0;
                else if (g == 0) chain[g] <= d_in;
                else chain[g] <= chain[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    assign d_out = chain[STAGES-1];
endmodule

// File: rtl/pen_filter.sv
// Tick-counting filter for the synchronized pin. A change is accepted when
// the pin has differed from the accepted value for the selected number of
// ticks; any return to the accepted value restarts the count. Selection 0
// bypasses the count. Emits one-cycle rise/fall flags with the change.
module pen_filter #(
    parameter int DB_SHORT = 25,
    parameter int DB_MID   = 50,
    parameter int DB_LONG  = 100
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [1:0] dbnc_sel,
    input  logic       pin_s,
    output logic       flt,
    output logic       rise,
    output logic       fall
);
    localparam int CW = $clog2(DB_LONG + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] limit;

    // choose the tick count for the selected filter length
    always_comb begin
        case (dbnc_sel)
            2'd1:    limit = CW'(DB_SHORT);
            2'd2:    limit = CW'(DB_MID);
            default: limit = CW'(DB_LONG);
        endcase
    end

    // count qualifying ticks and flip the accepted value when done
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flt  <= 1'b0;
            cnt  <= '0;
            rise <= 1'b0;
            fall <= 1'b0;
        end else begin
            rise <= 1'b0;
            fall <= 1'b0;
            if (dbnc_sel == 2'd0) begin
                cnt <= '0;
                flt <= pin_s;
                rise <= pin_s & ~flt;
                fall <= ~pin_s & flt;
            end else if (pin_s == flt) begin
                cnt <= '0;
            end else if (tick) begin
                if (cnt == limit - 1'b1) begin
                    cnt  <= '0;
                    flt  <= pin_s;
                    rise <= pin_s;
                    fall <= ~pin_s;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // R2
    hold_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dbnc_sel != 2'd0 && !tick) |=> $stable(flt));
    // R2
    rise_matches_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |-> (flt && !fall));
endmodule

// File: rtl/req_core.sv
// Request decision: merges automatic, software and pin sources into a
// stored request, applies shutdown/off priority, gates with lockout and
// registers the result. Assumes strobes and flags are synchronous.
module req_core
    import pwr_req_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       shdn,
    input  logic       uvlo,
    input  logic       sw_on,
    input  logic       sw_off,
    input  logic [1:0] src_sel,
    input  logic [1:0] pin_mode,
    input  logic       pin_rise,
    input  logic       pin_fall,
    output logic       pwr_req
);
    logic latch_q, latch_d;
    logic auto_done, auto_fire;
    src_e      src;
    pin_mode_e pm;

    assign src = src_e'(src_sel);
    assign pm  = pin_mode_e'(pin_mode);
    assign auto_fire = (src == SRC_AUTO) && !auto_done && tick && !uvlo && !shdn;

    // next stored request, highest priority first
    always_comb begin
        latch_d = latch_q;
        if (shdn) latch_d = 1'b0;
        else if (sw_off) latch_d = 1'b0;
        else if (sw_on) latch_d = 1'b1;
        else if (auto_fire) latch_d = 1'b1;
        else if (src == SRC_PIN) begin
            case (pm)
                PM_EDGE:   if (pin_rise) latch_d = 1'b1;
                PM_BUTTON: if (pin_fall) latch_d = ~latch_q;
                default: begin
                    if (pin_rise) latch_d = 1'b1;
                    else if (pin_fall) latch_d = 1'b0;
                end
            endcase
        end
    end

    // store request, remember the one automatic start, register output
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q   <= 1'b0;
            auto_done <= 1'b0;
            pwr_req   <= 1'b0;
        end else begin
            latch_q <= latch_d;
            if (auto_fire) auto_done <= 1'b1;
            pwr_req <= latch_d & ~uvlo & ~shdn;
        end
    end

    // R9
    sw_off_forces_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_off |=> !pwr_req);
    // R10
    shdn_forces_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shdn |=> !pwr_req);
    // R11
    uvlo_blocks_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uvlo |=> !pwr_req);
    // R7
    auto_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_done && src == SRC_AUTO && !sw_on && !latch_q) |=> !latch_q);
endmodule

// File: rtl/edge_pulse.sv
// Turns the registered request level into one-cycle start/stop pulses.
// Assumes the level is a flop output.
module edge_pulse (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic on_pulse,
    output logic off_pulse
);
    logic prev_q;

    // keep last cycle's level for edge comparison
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else prev_q <= level;
    end

    assign on_pulse  = level & ~prev_q;
    assign off_pulse = ~level & prev_q;

    // R12
    start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        on_pulse |=> !on_pulse);
    // R12
    stop_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        off_pulse |=> !off_pulse);
endmodule

// File: rtl/pwr_req_ctrl.sv
// Top of the power-request controller: pin synchronizer, tick filter,
// request decision and pulse generation. Assumes tick_ms is a one-cycle
// pulse synchronous to clk.
module pwr_req_ctrl #(
    parameter int SYNC_STAGES = 2,
    parameter int DB_SHORT    = 25,
    parameter int DB_MID      = 50,
    parameter int DB_LONG     = 100
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_ms,
    input  logic       pen_pin,
    input  logic       shdn,
    input  logic       uvlo,
    input  logic       sw_on,
    input  logic       sw_off,
    input  logic [1:0] src_sel,
    input  logic [1:0] pin_mode,
    input  logic [1:0] dbnc_sel,
    output logic       pwr_req,
    output logic       seq_start,
    output logic       seq_stop
);
    logic pin_s, pin_flt, pin_rise, pin_fall;

    pen_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_in(pen_pin), .d_out(pin_s)
    );

    pen_filter #(.DB_SHORT(DB_SHORT), .DB_MID(DB_MID), .DB_LONG(DB_LONG)) u_filt (
        .clk(clk), .rst_n(rst_n), .tick(tick_ms), .dbnc_sel(dbnc_sel),
        .pin_s(pin_s), .flt(pin_flt), .rise(pin_rise), .fall(pin_fall)
    );

    req_core u_core (
        .clk(clk), .rst_n(rst_n), .tick(tick_ms), .shdn(shdn), .uvlo(uvlo),
        .sw_on(sw_on), .sw_off(sw_off), .src_sel(src_sel), .pin_mode(pin_mode),
        .pin_rise(pin_rise), .pin_fall(pin_fall), .pwr_req(pwr_req)
    );

    edge_pulse u_pulse (
        .clk(clk), .rst_n(rst_n), .level(pwr_req),
        .on_pulse(seq_start), .off_pulse(seq_stop)
    );

    // R1
    quiet_after_reset_chk: assert property (@(posedge clk)
        !rst_n |=> (!pwr_req && !seq_start && !seq_stop));
endmodule

// File: tb/sim_pwr_req_ctrl.sv
module sim_pwr_req_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_ms = 1'b0, pen_pin = 1'b0, shdn = 1'b0, uvlo = 1'b0;
    logic sw_on = 1'b0, sw_off = 1'b0;
    logic [1:0] src_sel = 2'd0, pin_mode = 2'd0, dbnc_sel = 2'd0;
    logic pwr_req, seq_start, seq_stop;

    int n_tests = 0;
    int n_fail = 0;
    bit done = 0;
    bit exp_q[$];

    always #2.5 clk = ~clk;

    pwr_req_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .pen_pin(pen_pin),
        .shdn(shdn), .uvlo(uvlo), .sw_on(sw_on), .sw_off(sw_off),
        .src_sel(src_sel), .pin_mode(pin_mode), .dbnc_sel(dbnc_sel),
        .pwr_req(pwr_req), .seq_start(seq_start), .seq_stop(seq_stop)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick_ms = 1'b1; step(1);
            tick_ms = 1'b0; step(2);
        end
    endtask

    task automatic push(input bit ev);  // 1 = start pulse, 0 = stop pulse
        exp_q.push_back(ev);
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: pwr_req=%0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset(input logic [1:0] s, input logic [1:0] m,
                            input logic [1:0] d, input logic p);
        if (exp_q.size() != 0) begin
            n_tests++; n_fail++;
            $display("FAIL R12: %0d pulses missing, expected 0", exp_q.size());
            exp_q.delete();
        end
        rst_n = 1'b0; src_sel = s; pin_mode = m; dbnc_sel = d; pen_pin = p;
        step(3);
        rst_n = 1'b1;
        step(1);
    endtask

    task automatic strobe_on();
        sw_on = 1'b1; step(1); sw_on = 1'b0;
    endtask

    task automatic strobe_off();
        sw_off = 1'b1; step(1); sw_off = 1'b0;
    endtask

    // monitor: compare each produced pulse with the scoreboard queue
    always @(negedge clk) begin
        if (rst_n && !done && (seq_start || seq_stop)) begin
            n_tests++;
            if (seq_start && seq_stop) begin
                n_fail++;
                $display("FAIL R12: start=1 stop=1, expected only one");
            end else if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R12: unexpected pulse start=%0b, expected none", seq_start);
            end else begin
                bit e;
                e = exp_q.pop_front();
                if (e != seq_start) begin
                    n_fail++;
                    $display("FAIL R12: pulse start=%0b expected start=%0b", seq_start, e);
                end
            end
        end
    end

    initial begin
        step(100000);
        if (!done) begin
            n_fail++; n_tests++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        // R1 reset state, automatic source with lockout
        uvlo = 1'b1;
        do_reset(2'd0, 2'd0, 2'd0, 1'b0);
        chk("R1", pwr_req, 1'b0);
        chk("R1 start", seq_start, 1'b0);
        chk("R1 stop", seq_stop, 1'b0);
        ticks(2);
        chk("R11 auto under uvlo", pwr_req, 1'b0);
        uvlo = 1'b0;
        push(1'b1);
        ticks(1); step(1);
        chk("R7 auto start", pwr_req, 1'b1);
        push(1'b0);
        strobe_off(); step(1);
        chk("R9 sw off", pwr_req, 1'b0);
        ticks(3);
        chk("R7 auto only once", pwr_req, 1'b0);

        // R8 / R11 / R10
        push(1'b1); strobe_on(); step(1);
        chk("R8 sw on", pwr_req, 1'b1);
        push(1'b0); uvlo = 1'b1; step(2);
        chk("R11 uvlo gates", pwr_req, 1'b0);
        push(1'b1); uvlo = 1'b0; step(2);
        chk("R11 resume", pwr_req, 1'b1);
        push(1'b0); shdn = 1'b1; step(2);
        chk("R10 shdn off", pwr_req, 1'b0);
        strobe_on(); step(1);
        chk("R10 sw_on ignored", pwr_req, 1'b0);
        shdn = 1'b0; step(3);
        chk("R10 stays off", pwr_req, 1'b0);

        // R4 level, no filter
        do_reset(2'd2, 2'd0, 2'd0, 1'b0);
        push(1'b1); pen_pin = 1'b1; step(5);
        chk("R4 level on", pwr_req, 1'b1);
        push(1'b0); pen_pin = 1'b0; step(5);
        chk("R4 level off", pwr_req, 1'b0);
        push(1'b1); pen_pin = 1'b1; step(5);
        push(1'b0);
        sw_on = 1'b1; sw_off = 1'b1; step(1); sw_on = 1'b0; sw_off = 1'b0;
        step(1);
        chk("R9 off wins", pwr_req, 1'b0);
        step(5);
        chk("R9 pin high ignored", pwr_req, 1'b0);

        // R2 / R3 level, 100-tick filter
        do_reset(2'd2, 2'd0, 2'd3, 1'b0);
        pen_pin = 1'b1; step(3); ticks(99);
        chk("R2 100-1 ticks", pwr_req, 1'b0);
        push(1'b1); ticks(1);
        chk("R2 100 ticks", pwr_req, 1'b1);
        pen_pin = 1'b0; step(3); ticks(60);
        pen_pin = 1'b1; step(3); ticks(60);
        chk("R3 glitch ignored", pwr_req, 1'b1);
        pen_pin = 1'b0; step(3); ticks(99);
        chk("R3 restarted count", pwr_req, 1'b1);
        push(1'b0); ticks(1);
        chk("R2 off after 100", pwr_req, 1'b0);
        dbnc_sel = 2'd1;
        pen_pin = 1'b1; step(3); ticks(24);
        chk("R2 25-1 ticks", pwr_req, 1'b0);
        push(1'b1); ticks(1);
        chk("R2 25 ticks", pwr_req, 1'b1);

        // R5 edge mode
        do_reset(2'd2, 2'd1, 2'd0, 1'b0);
        push(1'b1); pen_pin = 1'b1; step(5);
        chk("R5 edge on", pwr_req, 1'b1);
        pen_pin = 1'b0; step(5);
        chk("R5 fall no effect", pwr_req, 1'b1);
        push(1'b0); strobe_off(); step(1);
        chk("R5 off by sw", pwr_req, 1'b0);
        push(1'b1); pen_pin = 1'b1; step(5);
        chk("R5 edge again", pwr_req, 1'b1);

        // R6 push-button, 50-tick filter, idle high
        do_reset(2'd2, 2'd2, 2'd2, 1'b1);
        step(3); ticks(50);
        chk("R6 rise no effect", pwr_req, 1'b0);
        pen_pin = 1'b0; step(3); ticks(49);
        chk("R6 short press", pwr_req, 1'b0);
        push(1'b1); ticks(1);
        chk("R6 press on", pwr_req, 1'b1);
        pen_pin = 1'b1; step(3); ticks(50);
        chk("R6 release kept", pwr_req, 1'b1);
        pen_pin = 1'b0; step(3); ticks(49);
        chk("R6 second short", pwr_req, 1'b1);
        push(1'b0); ticks(1);
        chk("R6 press off", pwr_req, 1'b0);

        // R8 software source ignores the pin
        do_reset(2'd1, 2'd0, 2'd0, 1'b0);
        pen_pin = 1'b1; step(5);
        chk("R8 pin ignored", pwr_req, 1'b0);
        push(1'b1); strobe_on(); step(1);
        chk("R8 sw start", pwr_req, 1'b1);

        step(4);
        n_tests++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL R12: %0d pulses missing, expected 0", exp_q.size());
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule